// File: doc/BRIEF.md
# Monotonic Multi-Stream Wall Clock

This block keeps a 64-bit wall-clock register for a group of audio streams. The register moves forward only when every stream that takes part has reached the time being asked for. This keeps the published time from ever running ahead of any stream. Each stream reports its absolute elapsed count, and an active mask says which streams are taken into account.

A caller issues a one-cycle request that carries a target value and a force flag. A forced request loads the target as it stands. An unforced request is honoured only if each active stream's elapsed count is at or beyond the target. When it is honoured, the register jumps to the largest of the target and the active elapsed counts.

One cycle after each request the block reports three things. It reports whether the register now holds the value the request resolved to. It flags an unforced write that lowers the clock. It flags an unforced write that repeats the current value too many times in a row.

Top module: `wclk_gate`

## Requirements
- R1: An unforced request while any active stream's elapsed count is below the target leaves the clock register unchanged.
- R2: A stream whose bit in the active mask is 0 is ignored both in the passed check and in the maximum; with no stream active an unforced request always writes.
- R3: An unforced request that is allowed writes the largest of the target and every active stream's elapsed count; a stream has passed when elapsed >= target, compared unsigned.
- R4: A forced request writes the target value whatever the stream counts and mask are.
- R5: An unforced write whose value is lower than the current clock still writes, and it raises `err_backward` for one cycle.
- R6: An unforced write equal to the current clock is a stale write. The stale count is taken before it is incremented. When that count is above 3, which means the fifth consecutive stale write and every one after it, `err_stale` pulses. An unforced write of a different value clears the count. Forced and blocked requests leave the count alone.
- R7: `req_accepted` is 1 when the clock after the request equals the resolved value. The resolved value is the computed maximum for an allowed unforced request and the target otherwise. A blocked request is therefore accepted only if the clock already equals the target.
- R8: `req_done`, `req_accepted`, `err_backward` and `err_stale` are valid in the cycle after the request cycle, and the clock updates on that same edge. In a cycle with no request all four flags are 0 and the clock holds.
- R9: Reset sets the clock to 0, clears the stale count and drives all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle update request |
| req_force | input | 1 | Load the target directly |
| req_value | input | 64 | Requested target time |
| strm_active | input | 3 | Streams taking part in the check |
| strm_elapsed | input | 192 | Elapsed counts; stream i at bits [64*i+63:64*i] |
| clock_value | output | 64 | Current wall-clock value |
| req_done | output | 1 | Result of the previous cycle's request is valid |
| req_accepted | output | 1 | Clock equals the resolved value |
| err_backward | output | 1 | Unforced write lowered the clock |
| err_stale | output | 1 | Repeated stale write past the limit |

## Verification
The assertions assume that `req_value`, `req_force`, `strm_active` and `strm_elapsed` are steady around the sampling edge of a request. They also assume that `req_valid` is the only thing that starts an update, so any clock change in a cycle without a request is an error. The stimulus changes inputs only on the falling edge. It raises `req_valid` for exactly one cycle per request and always inserts at least one idle cycle between requests. This makes the one-cycle-later result and the idle hold both observable.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
  localparam int unsigned WCLK_W = 64;

  function automatic logic [WCLK_W-1:0] wclk_max(input logic [WCLK_W-1:0] a,
                                                 input logic [WCLK_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic wclk_reached(input logic [WCLK_W-1:0] elapsed,
                                        input logic [WCLK_W-1:0] target);
    return elapsed >= target;
  endfunction
endpackage

// File: rtl/wclk_stream_cmp.sv
module wclk_stream_cmp
  import wclk_pkg::*;
(
  input  logic              active,
  input  logic [WCLK_W-1:0] elapsed,
  input  logic [WCLK_W-1:0] target,
  output logic              ok,
  output logic [WCLK_W-1:0] contrib
);
  always_comb begin
    ok      = !active || wclk_reached(elapsed, target);
    contrib = active ? elapsed : '0;
  end
endmodule

// File: rtl/wclk_max_tree.sv
module wclk_max_tree
  import wclk_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic [WCLK_W-1:0]   seed,
  input  logic [N*WCLK_W-1:0] vals,
  output logic [WCLK_W-1:0]   peak
);
  always_comb begin
    peak = seed;
    for (int i = 0; i < N; i++) begin
      peak = wclk_max(peak, vals[i*WCLK_W +: WCLK_W]);
    end
  end
endmodule

// File: rtl/wclk_stale_track.sv
module wclk_stale_track #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_unforced,
  input  logic same_val,
  output logic stale_hit
);
  localparam int unsigned CAP = LIMIT + 1;
  localparam int unsigned CW  = $clog2(CAP + 1);

  logic [CW-1:0] cnt;

  assign stale_hit = wr_unforced && same_val && (cnt > CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_unforced) begin
      if (!same_val)             cnt <= '0;
      else if (cnt != CW'(CAP))  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wclk_gate.sv
module wclk_gate
  import wclk_pkg::*;
#(
  parameter int unsigned NSTREAM     = 3,
  parameter int unsigned STALE_LIMIT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_force,
  input  logic [WCLK_W-1:0]         req_value,
  input  logic [NSTREAM-1:0]        strm_active,
  input  logic [NSTREAM*WCLK_W-1:0] strm_elapsed,
  output logic [WCLK_W-1:0]         clock_value,
  output logic                      req_done,
  output logic                      req_accepted,
  output logic                      err_backward,
  output logic                      err_stale
);
  logic [NSTREAM-1:0]        pass_vec;
  logic [NSTREAM*WCLK_W-1:0] contrib;
  logic                      all_passed;
  logic [WCLK_W-1:0]         peak;
  logic                      unforced_wr;
  logic                      write_en;
  logic [WCLK_W-1:0]         new_val;
  logic [WCLK_W-1:0]         next_clock;
  logic [WCLK_W-1:0]         resolved;
  logic                      backward_hit;
  logic                      stale_hit;

  for (genvar g = 0; g < NSTREAM; g++) begin : g_strm
    wclk_stream_cmp u_cmp (
      .active  (strm_active[g]),
      .elapsed (strm_elapsed[g*WCLK_W +: WCLK_W]),
      .target  (req_value),
      .ok      (pass_vec[g]),
      .contrib (contrib[g*WCLK_W +: WCLK_W])
    );
  end

  wclk_max_tree #(.N(NSTREAM)) u_max (
    .seed (req_value),
    .vals (contrib),
    .peak (peak)
  );

  always_comb begin
    all_passed   = &pass_vec;
    unforced_wr  = req_valid && !req_force && all_passed;
    write_en     = req_valid && (req_force || all_passed);
    new_val      = req_force ? req_value : peak;
    next_clock   = write_en ? new_val : clock_value;
    resolved     = unforced_wr ? peak : req_value;
    backward_hit = unforced_wr && (peak < clock_value);
  end

  wclk_stale_track #(.LIMIT(STALE_LIMIT)) u_stale (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_unforced (unforced_wr),
    .same_val    (peak == clock_value),
    .stale_hit   (stale_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clock_value  <= '0;
      req_done     <= 1'b0;
      req_accepted <= 1'b0;
      err_backward <= 1'b0;
      err_stale    <= 1'b0;
    end else begin
      clock_value  <= next_clock;
      req_done     <= req_valid;
      req_accepted <= req_valid && (next_clock == resolved);
      err_backward <= backward_hit;
      err_stale    <= stale_hit;
    end
  end

  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_force && !all_passed |=> $stable(clock_value)); // R1
  AST_UNFORCED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_force && all_passed |=> clock_value >= $past(req_value)); // R3
  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_force |=> clock_value == $past(req_value)); // R4
  AST_RAISE_OR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_force |=> (clock_value >= $past(clock_value)) || err_backward); // R5
  AST_STALE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_stale |-> req_done && $stable(clock_value)); // R6
  AST_FORCE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_force |=> req_accepted); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !req_done && !req_accepted && !err_backward && !err_stale
                   && $stable(clock_value)); // R8
endmodule

// File: tb/wclk_gate_tb.sv
module wclk_gate_tb;
  localparam int W = 64;
  localparam int N = 3;

  typedef struct packed {
    logic [W-1:0] clk_v;
    logic         acc;
    logic         back;
    logic         stale;
    logic [7:0]   req;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_force = 1'b0;
  logic [W-1:0]   req_value = '0;
  logic [N-1:0]   strm_active = '0;
  logic [N*W-1:0] strm_elapsed = '0;
  logic [W-1:0]   clock_value;
  logic           req_done, req_accepted, err_backward, err_stale;

  int   n_checks = 0;
  int   n_fails  = 0;
  exp_t sb[$];
  logic [W-1:0] m_clk = '0;
  int   m_stale = 0;

  always #4 clk = ~clk;

  wclk_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_force(req_force),
    .req_value(req_value), .strm_active(strm_active), .strm_elapsed(strm_elapsed),
    .clock_value(clock_value), .req_done(req_done), .req_accepted(req_accepted),
    .err_backward(err_backward), .err_stale(err_stale)
  );

  task automatic chk(input logic ok, input int rq, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Bench model, written from the requirements
  task automatic send(input int rq, input logic frc, input logic [W-1:0] tgt,
                      input logic [N-1:0] act,
                      input logic [W-1:0] e0, input logic [W-1:0] e1,
                      input logic [W-1:0] e2);
    logic [W-1:0] ev [N];
    logic         ok_all;
    logic [W-1:0] top_v, res;
    exp_t e;
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    ok_all = 1'b1;
    top_v  = tgt;
    for (int i = 0; i < N; i++) begin
      if (act[i]) begin
        if (ev[i] < tgt) ok_all = 1'b0;
        if (ev[i] > top_v) top_v = ev[i];
      end
    end
    e = '0;
    e.req = 8'(rq);
    if (frc) begin
      m_clk = tgt; res = tgt;
    end else if (ok_all) begin
      e.back = top_v < m_clk;
      if (top_v == m_clk) begin
        e.stale = m_stale > 3;
        m_stale++;
      end else m_stale = 0;
      m_clk = top_v; res = top_v;
    end else begin
      res = tgt;
    end
    e.clk_v = m_clk;
    e.acc   = (m_clk == res);
    @(negedge clk);
    req_valid = 1'b1; req_force = frc; req_value = tgt; strm_active = act;
    strm_elapsed = {e2, e1, e0};
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && req_done) begin
      if (sb.size() == 0) begin
        chk(1'b0, 8, 0, 1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(clock_value == e.clk_v, int'(e.req), clock_value, e.clk_v);
        chk(req_accepted == e.acc, 7, W'(req_accepted), W'(e.acc));
        chk(err_backward == e.back, 5, W'(err_backward), W'(e.back));
        chk(err_stale == e.stale, 6, W'(err_stale), W'(e.stale));
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(clock_value == 0, 9, clock_value, 0);
        chk(!req_done && !req_accepted && !err_backward && !err_stale, 9,
            W'({req_done, req_accepted, err_backward, err_stale}), 0);
        rst_n = 1'b1;
        send(4, 1'b1, 64'd100, 3'b111, 0, 0, 0);              // R4 forced load
        send(3, 1'b0, 64'd150, 3'b111, 160, 170, 155);        // R3 jump to max
        send(1, 1'b0, 64'd200, 3'b111, 210, 190, 220);        // R1 blocked
        repeat (3) @(negedge clk);
        // R8: clock holds while idle
        chk(clock_value == 64'd170, 8, clock_value, 64'd170);
        send(2, 1'b0, 64'd200, 3'b101, 210, 190, 220);        // R2 inactive ignored
        send(2, 1'b0, 64'd300, 3'b000, 5, 5, 5);              // R2 none active
        send(5, 1'b0, 64'd50, 3'b111, 60, 60, 60);            // R5 backwards
        for (int k = 0; k < 6; k++) send(6, 1'b0, 64'd60, 3'b111, 60, 60, 60); // R6 stale
        send(6, 1'b0, 64'd61, 3'b111, 61, 61, 61);            // R6 clears count
        for (int k = 0; k < 4; k++) send(6, 1'b0, 64'd61, 3'b111, 61, 61, 61);
        send(4, 1'b1, 64'd500, 3'b111, 1, 2, 3);              // R4 streams behind
        send(7, 1'b0, 64'd500, 3'b111, 499, 600, 600);        // R7 blocked, equal
        send(7, 1'b0, 64'd700, 3'b111, 699, 800, 800);        // R7 blocked, differ
        send(3, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 3'b111,
             64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF1);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, 8, W'(sb.size()), 0);
      end
      begin
        repeat (20000) @(negedge clk);
        chk(1'b0, 8, 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule